// File: doc/BRIEF.md
# Masked Device Interrupt Router

This block delivers level interrupts from a 64-bit vector of raw device requests to a small set of processors. Each processor owns a 64-bit mask word. The block keeps a per-processor effective request word, which is the mask ANDed with the raw request vector. Each processor's interrupt output is a registered OR over its effective word. Software programs the masks over a simple register bus and can read back both the masks and the effective words.

The interrupt outputs are driven from a per-processor pending vector, not directly from the effective word. That vector is updated only where something changed: a mask bit that a write flips, or a raw request bit that toggled. A changed bit is posted when it now contributes, and withdrawn when it contributed before and no longer does. Rewriting a mask with its current value therefore leaves every output alone.

Bus accesses must be 64 bits wide and must hit a mapped register. Any other access sets a sticky error flag, returns zero if it is a read, and changes no state.

Top module: `irq_mask_router`

## Requirements
- R1: After a cycle with `rst` high, every mask word, every effective word, every `irq_o` bit, `err_o` and `rsp_valid` are zero.
- R2: A legal write with `req_addr[11:10]` = 2'b00 replaces the mask of the processor selected by `req_addr[9:4]` at the next clock edge. Masks of the other processors do not change.
- R3: Each effective word equals its mask ANDed with the value `raw_irq` had at the most recent clock edge. It updates at the same edge as the mask write or the raw change that affects it.
- R4: A processor's interrupt moves only for bit positions whose mask or raw bit changed. Rewriting an unchanged mask, or flipping mask bits whose raw request is low, leaves `irq_o` unchanged. Clearing the last contributing bit drops `irq_o`.
- R5: `irq_o[p]` equals the OR of processor p's effective word one cycle after that word takes its value. This is two edges after a mask write.
- R6: A read asserts `rsp_valid` on the next cycle. `rsp_rdata` carries the mask for `req_addr[11:10]` = 2'b00 and the effective word for 2'b01. When no read is answered, `rsp_rdata` is zero.
- R7: `req_size` 2'b11 is a 64-bit access and the only legal size. Codes 2'b00, 2'b01 and 2'b10 (8, 16 and 32 bits) are errors.
- R8: These accesses are unmapped: nonzero `req_addr[3:0]`, `req_addr[11:10]` of 2'b10 or 2'b11, a processor index of NCPU or more, and any write to an effective word. An unmapped or wrongly sized access sets `err_o`, returns zero on a read and leaves all state unchanged.
- R9: `err_o` stays high once set, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code (2'b11 = 64-bit) |
| req_addr | input | 12 | Byte offset: [11:10] register kind, [9:4] processor index, [3:0] must be zero |
| req_wdata | input | DW | Write data |
| raw_irq | input | DW | Raw device request vector |
| rsp_valid | output | 1 | Read response present |
| rsp_rdata | output | DW | Read data |
| err_o | output | 1 | Sticky access error flag |
| irq_o | output | NCPU | Level interrupt, one per processor |

## Verification
Masks are first written over a fixed raw vector, once with a value that overlaps the raw bits and once with a value that does not. This separates the AND from a plain copy of the mask. An identical rewrite and a flip of mask bits that have no raw request check that the output follows only contributing changes. The raw vector is then moved under constant masks, which shows that raw changes reach the effective word without any bus write. Reads with each illegal size and at each kind of unmapped offset, followed by reads of the targeted mask, tell error handling apart from silently accepted writes. A long stretch of mixed random traffic is compared every cycle against a behavioural model.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int ADDR_W    = 12;
  localparam int CPU_FLD_W = 6;
  localparam int CPU_LSB   = 4;
  localparam int KIND_LSB  = 10;

  typedef enum logic [1:0] {
    SZ_B8  = 2'b00,
    SZ_B16 = 2'b01,
    SZ_B32 = 2'b10,
    SZ_B64 = 2'b11
  } acc_size_e;

  typedef enum logic [1:0] {
    KIND_MASK = 2'b00,
    KIND_EFF  = 2'b01,
    KIND_RSV2 = 2'b10,
    KIND_RSV3 = 2'b11
  } reg_kind_e;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_router_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [1:0]           req_size,
  input  logic [ADDR_W-1:0]    req_addr,
  output logic [NCPU-1:0]      mask_we,
  output logic                 rd_hit,
  output reg_kind_e            rd_kind,
  output logic [CPU_FLD_W-1:0] sel_cpu,
  output logic                 bad
);
  reg_kind_e kind;
  logic size_ok, align_ok, kind_ok, cpu_ok, dir_ok, legal;

  always_comb begin
    kind     = reg_kind_e'(req_addr[KIND_LSB +: 2]);
    sel_cpu  = req_addr[CPU_LSB +: CPU_FLD_W];
    size_ok  = (acc_size_e'(req_size) == SZ_B64);
    align_ok = (req_addr[CPU_LSB-1:0] == '0);
    kind_ok  = (kind == KIND_MASK) || (kind == KIND_EFF);
    cpu_ok   = (int'(sel_cpu) < NCPU);
    dir_ok   = !(req_write && (kind == KIND_EFF));
    legal    = size_ok && align_ok && kind_ok && cpu_ok && dir_ok;
    bad      = req_valid && !legal;
    rd_hit   = req_valid && !req_write && legal;
    rd_kind  = kind;
  end

  for (genvar p = 0; p < NCPU; p++) begin : g_we
    assign mask_we[p] = req_valid && req_write && legal && (kind == KIND_MASK)
                        && (int'(sel_cpu) == p);
  end
endmodule

// File: rtl/irq_cpu_lane.sv
module irq_cpu_lane #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] raw_now,
  input  logic [DW-1:0] raw_last,
  output logic [DW-1:0] mask_o,
  output logic [DW-1:0] eff_o,
  output logic          irq_o
);
  logic [DW-1:0] mask_q, eff_q, pend_q;
  logic [DW-1:0] mask_d, eff_d, chg, post_v, drop_v;
  logic          irq_q;

  always_comb begin
    mask_d = wr_en ? wr_data : mask_q;
    eff_d  = mask_d & raw_now;
    // only positions whose mask or raw bit moved are examined
    chg    = (mask_d ^ mask_q) | (raw_now ^ raw_last);
    post_v = chg & mask_d & eff_d;
    drop_v = chg & eff_q & ~eff_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      eff_q  <= '0;
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      eff_q  <= eff_d;
      pend_q <= (pend_q | post_v) & ~drop_v;
      irq_q  <= |pend_q;
    end
  end

  assign mask_o = mask_q;
  assign eff_o  = eff_q;
  assign irq_o  = irq_q;

  assert_eff_is_and_R3: assert property (@(posedge clk) disable iff (rst)
    eff_q == (mask_q & raw_last));
  assert_pend_tracks_R4: assert property (@(posedge clk) disable iff (rst)
    pend_q == eff_q);
  assert_irq_lag_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == $past(|eff_q)));
  assert_mask_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(mask_q));
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irq_router_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int DW   = 64
) (
  input  logic [DW-1:0]        masks [NCPU],
  input  logic [DW-1:0]        effs  [NCPU],
  input  reg_kind_e            kind,
  input  logic [CPU_FLD_W-1:0] cpu,
  input  logic                 hit,
  output logic [DW-1:0]        rdata
);
  always_comb begin
    rdata = '0;
    for (int p = 0; p < NCPU; p++) begin
      if (hit && (int'(cpu) == p)) begin
        rdata = (kind == KIND_EFF) ? effs[p] : masks[p];
      end
    end
  end
endmodule

// File: rtl/irq_mask_router.sv
module irq_mask_router
  import irq_router_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int DW   = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [DW-1:0]     raw_irq,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic              err_o,
  output logic [NCPU-1:0]   irq_o
);
  logic [NCPU-1:0]      mask_we;
  logic                 rd_hit, bad;
  reg_kind_e            rd_kind;
  logic [CPU_FLD_W-1:0] sel_cpu;
  logic [DW-1:0]        raw_q;
  logic [DW-1:0]        masks [NCPU];
  logic [DW-1:0]        effs  [NCPU];
  logic [DW-1:0]        rd_mux;
  logic                 rv_q, err_q;
  logic [DW-1:0]        rd_q;

  irq_reg_decode #(.NCPU(NCPU)) u_dec (
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .mask_we(mask_we), .rd_hit(rd_hit),
    .rd_kind(rd_kind), .sel_cpu(sel_cpu), .bad(bad)
  );

  for (genvar p = 0; p < NCPU; p++) begin : g_lane
    irq_cpu_lane #(.DW(DW)) u_lane (
      .clk(clk), .rst(rst), .wr_en(mask_we[p]), .wr_data(req_wdata),
      .raw_now(raw_irq), .raw_last(raw_q),
      .mask_o(masks[p]), .eff_o(effs[p]), .irq_o(irq_o[p])
    );
  end

  irq_read_mux #(.NCPU(NCPU), .DW(DW)) u_rmux (
    .masks(masks), .effs(effs), .kind(rd_kind), .cpu(sel_cpu),
    .hit(rd_hit), .rdata(rd_mux)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= '0;
      rv_q  <= 1'b0;
      rd_q  <= '0;
      err_q <= 1'b0;
    end else begin
      raw_q <= raw_irq;
      rv_q  <= req_valid && !req_write;
      rd_q  <= rd_mux;
      err_q <= err_q || bad;
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_rdata = rd_q;
  assign err_o     = err_q;

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (irq_o == '0 && !err_o && !rsp_valid));
  assert_bad_read_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && bad) |=> (rsp_valid && rsp_rdata == '0));
  assert_bad_sets_err_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && bad) |=> err_o);
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);
  assert_read_answer_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rsp_valid);
endmodule

// File: tb/irq_mask_router_test.sv
module irq_mask_router_test;
  localparam int NCPU = 4;
  localparam int DW   = 64;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]      req_size = 2'b11;
  logic [11:0]     req_addr = '0;
  logic [DW-1:0]   req_wdata = '0, raw_irq = '0;
  logic            rsp_valid, err_o;
  logic [DW-1:0]   rsp_rdata;
  logic [NCPU-1:0] irq_o;

  always #2 clk = ~clk;

  irq_mask_router #(.NCPU(NCPU), .DW(DW)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .raw_irq(raw_irq), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .err_o(err_o), .irq_o(irq_o)
  );

  int nvec = 0, nbad = 0;
  bit done = 0;

  // behavioural reference
  logic [DW-1:0]   m_mask [NCPU];
  logic [DW-1:0]   m_eff  [NCPU];
  logic [NCPU-1:0] m_irq;
  logic            m_err, m_rv;
  logic [DW-1:0]   m_rd;

  task automatic model_edge();
    if (rst) begin
      for (int p = 0; p < NCPU; p++) begin m_mask[p] = '0; m_eff[p] = '0; end
      m_irq = '0; m_err = 0; m_rv = 0; m_rd = '0;
    end else begin
      int  kind = int'(req_addr[11:10]);
      int  idx  = int'(req_addr[9:4]);
      bit  ok   = (req_size == 2'b11) && (req_addr[3:0] == 0) && (kind <= 1)
                  && (idx < NCPU) && !(req_write && kind == 1);
      for (int p = 0; p < NCPU; p++) m_irq[p] = |m_eff[p];
      m_rv = req_valid && !req_write;
      m_rd = '0;
      if (req_valid && !req_write && ok) m_rd = (kind == 1) ? m_eff[idx] : m_mask[idx];
      if (req_valid && !ok) m_err = 1;
      if (req_valid && req_write && ok) m_mask[idx] = req_wdata;
      for (int p = 0; p < NCPU; p++) m_eff[p] = m_mask[p] & raw_irq;
    end
  endtask

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    #1;
    chk("R5 irq_o", {60'b0, irq_o}, {60'b0, m_irq});
    chk("R9 err_o", {63'b0, err_o}, {63'b0, m_err});
    chk("R6 rsp_valid", {63'b0, rsp_valid}, {63'b0, m_rv});
    chk("R6 rsp_rdata", rsp_rdata, m_rd);
  endtask

  function automatic logic [11:0] ad(int kind, int cpu);
    return {kind[1:0], cpu[5:0], 4'b0};
  endfunction

  task automatic bus(bit wr, logic [11:0] a, logic [1:0] sz, logic [DW-1:0] d);
    req_valid = 1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
    tick();
    req_valid = 0; req_write = 0; req_size = 2'b11;
  endtask

  task automatic rd_chk(logic [11:0] a, logic [DW-1:0] exp, string tag);
    bus(0, a, 2'b11, '0);
    chk(tag, rsp_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst = 0;
    chk("R1 irq after reset", {60'b0, irq_o}, '0);
    chk("R1 err after reset", {63'b0, err_o}, '0);
    rd_chk(ad(0, 0), '0, "R1 mask0 after reset");
    rd_chk(ad(1, 3), '0, "R1 eff3 after reset");

    raw_irq = 64'h0F;
    bus(1, ad(0, 0), 2'b11, 64'hFF);
    rd_chk(ad(1, 0), 64'h0F, "R3 eff0 = mask & raw");
    chk("R5 irq0 raised", {63'b0, irq_o[0]}, 64'd1);
    bus(1, ad(0, 1), 2'b11, 64'hF0);
    rd_chk(ad(0, 1), 64'hF0, "R2 mask1 readback");
    rd_chk(ad(0, 0), 64'hFF, "R2 mask0 untouched");
    tick();
    chk("R3 irq1 low, no overlap", {63'b0, irq_o[1]}, 64'd0);

    bus(1, ad(0, 0), 2'b11, 64'hFF); tick(); tick();
    chk("R4 same rewrite keeps irq0", {63'b0, irq_o[0]}, 64'd1);
    bus(1, ad(0, 0), 2'b11, 64'hFF0F); tick(); tick();
    chk("R4 flip of idle bits keeps irq0", {63'b0, irq_o[0]}, 64'd1);
    bus(1, ad(0, 0), 2'b11, 64'hFF00);
    chk("R5 irq0 still high one edge after", {63'b0, irq_o[0]}, 64'd1);
    tick();
    chk("R4 last bit cleared drops irq0", {63'b0, irq_o[0]}, 64'd0);

    raw_irq = 64'h30; tick(); tick();
    chk("R3 raw change raises irq1", {63'b0, irq_o[1]}, 64'd1);
    rd_chk(ad(1, 1), 64'h30, "R3 eff1 follows raw");

    rd_chk({2'b00, 6'd2, 4'b0}, '0, "R6 mask2 zero");
    bus(0, ad(0, 1), 2'b10, '0);
    chk("R7 32-bit read returns zero", rsp_rdata, '0);
    chk("R7 error set", {63'b0, err_o}, 64'd1);
    bus(1, ad(0, 2), 2'b00, 64'h1234);
    rd_chk(ad(0, 2), '0, "R7 8-bit write ignored");
    bus(1, ad(0, 5), 2'b11, 64'h55);
    bus(1, ad(1, 2), 2'b11, 64'h55);
    rd_chk(ad(0, 2), '0, "R8 eff write ignored");
    bus(0, ad(2, 0), 2'b11, '0);
    chk("R8 unmapped kind reads zero", rsp_rdata, '0);
    bus(1, ad(0, 3) | 12'h8, 2'b11, 64'hAA);
    rd_chk(ad(0, 3), '0, "R8 misaligned write ignored");
    repeat (5) tick();
    chk("R9 error sticky", {63'b0, err_o}, 64'd1);

    rst = 1; tick(); rst = 0;
    chk("R1 error cleared by reset", {63'b0, err_o}, '0);

    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 4) == 0) raw_irq = {$urandom, $urandom} & {$urandom, $urandom};
      if (($urandom % 2) == 0) begin
        req_valid = 1;
        req_write = ($urandom % 2) == 1;
        req_size  = (($urandom % 8) == 0) ? 2'($urandom) : 2'b11;
        req_addr  = {(($urandom % 6) == 0) ? 2'($urandom) : {1'b0, 1'($urandom)},
                     6'($urandom % 6), (($urandom % 10) == 0) ? 4'($urandom) : 4'b0};
        req_wdata = {$urandom, $urandom} & {$urandom, $urandom};
      end else begin
        req_valid = 0;
      end
      if (($urandom % 400) == 0) rst = 1; else rst = 0;
      tick();
    end
    req_valid = 0; rst = 0;
    tick();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule